// File: doc/BRIEF.md
# Switch-Configured Serial Port I/O Decoder

This block watches an 8-bit ISA-style I/O bus cycle on behalf of one serial port. It compares address lines 10 down to 3 with an eight-position configuration switch word. When they match, it raises a chip-select and hands the three low address bits to the attached UART as a register offset. Each port therefore owns a window of eight consecutive I/O locations inside an 11-bit space, from 0x000 to 0x7FF.

A closed switch forces its address line to compare against 0. An open switch requires a 1. The decode is purely combinational and has no clock. The read and write strobes leave the block only when the chip-select is active. A cycle with the address-enable qualifier high, meaning the DMA controller owns the bus, never selects the port. A port-enable input turns the whole port off. A dual-port card uses two instances, with switch words 0x80 (base 0x3F8) and 0xA0 (base 0x2F8) as the power-on settings.

Top module: `iodec_port`

## Requirements
- R1: Switch word bit i (i = 0..7) governs address bit i+3. A bit of 1 (switch closed) matches only when that address bit is 0. A bit of 0 (switch open) matches only when that address bit is 1. `sel_o` is 1 only when all eight positions match, `dma_aen_i` is 0 and `port_en_i` is 1.
- R2: Address bits 11 and above have no effect on `sel_o`, `reg_idx_o`, `rd_o` or `wr_o`.
- R3: While `dma_aen_i` is 1, `sel_o`, `rd_o` and `wr_o` are all 0.
- R4: While `port_en_i` is 0, `sel_o`, `rd_o` and `wr_o` are all 0.
- R5: `reg_idx_o` equals address bits 2..0 while `sel_o` is 1, and is 0 otherwise.
- R6: `rd_o` is 1 exactly when `sel_o` is 1 and `ior_n_i` is 0. `wr_o` is 1 exactly when `sel_o` is 1 and `iow_n_i` is 0.
- R7: A strobe asserted while the address is outside the window produces no `rd_o` or `wr_o`.
- R8: Switch words 0x80, 0xA0, 0x82 and 0xA2 select the windows starting at 0x3F8, 0x2F8, 0x3E8 and 0x2E8. In each case the window starts exactly at the base and ends at base+7, so neither base-1 nor base+8 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_addr_i | input | 16 | I/O address bus |
| dma_aen_i | input | 1 | Address-enable qualifier; 1 marks a DMA cycle |
| ior_n_i | input | 1 | I/O read strobe, active low |
| iow_n_i | input | 1 | I/O write strobe, active low |
| port_en_i | input | 1 | Port enable; 0 disables the port |
| sw_closed_i | input | 8 | Switch word; a bit of 1 is a closed switch |
| sel_o | output | 1 | Port chip-select |
| reg_idx_o | output | 3 | Register offset inside the port window |
| rd_o | output | 1 | Qualified read strobe, active high |
| wr_o | output | 1 | Qualified write strobe, active high |

## Verification
The assertions run on every evaluation of the logic. They check that a DMA cycle or a disabled port never selects, that the offset stays at zero while unselected, and that each qualified strobe appears only with both the select and its raw strobe. Only the bench scenarios can show the following:
- the switch polarity is right;
- the window edges sit exactly at base-1 and base+8 for the four customary bases;
- high address lines are truly ignored.

The bench covers these with directed sweeps and seeded random cycles.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
   // Shared widths of the decoder family.
   localparam int unsigned IODEC_OFS_W  = 3;
   localparam int unsigned IODEC_SW_W   = 8;
   localparam int unsigned IODEC_ADDR_W = 16;

   // Customary switch words for the two ports of a dual card.
   localparam logic [IODEC_SW_W-1:0] IODEC_SW_PORT_A = 8'h80; // base 0x3F8
   localparam logic [IODEC_SW_W-1:0] IODEC_SW_PORT_B = 8'hA0; // base 0x2F8

   typedef struct packed {
      logic                   sel;
      logic [IODEC_OFS_W-1:0] idx;
      logic                   rd;
      logic                   wr;
   } iodec_out_t;
endpackage

// File: rtl/iodec_line_match.sv
module iodec_line_match #(
   parameter int unsigned SW_W         = 8,
   parameter bit          CLOSED_IS_ONE = 1'b1
) (
   input  logic [SW_W-1:0] addr_field_i,
   input  logic [SW_W-1:0] sw_i,
   output logic            hit_o
);
   initial begin
      if (SW_W < 1) $error("iodec_line_match: SW_W must be at least 1");
   end

   logic [SW_W-1:0] bit_ok;

   for (genvar i = 0; i < SW_W; i++) begin : g_pos
      if (CLOSED_IS_ONE) begin : g_closed_one
         // closed (1) demands a 0 on the line, open demands a 1
         assign bit_ok[i] = addr_field_i[i] ^ sw_i[i];
      end else begin : g_closed_zero
         assign bit_ok[i] = ~(addr_field_i[i] ^ sw_i[i]);
      end
   end

   assign hit_o = &bit_ok;
endmodule

// File: rtl/iodec_strobe_gate.sv
module iodec_strobe_gate #(
   parameter int unsigned OFS_W = 3
) (
   input  logic             sel_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             ior_n_i,
   input  logic             iow_n_i,
   output logic [OFS_W-1:0] ofs_o,
   output logic             rd_o,
   output logic             wr_o
);
   assign ofs_o = sel_i ? ofs_i : '0;
   assign rd_o  = sel_i & ~ior_n_i;
   assign wr_o  = sel_i & ~iow_n_i;

   always_comb begin
      a_r6_rd_needs_sel: assert (!rd_o || (sel_i && !ior_n_i));
      a_r6_wr_needs_sel: assert (!wr_o || (sel_i && !iow_n_i));
   end
endmodule

// File: rtl/iodec_port.sv
module iodec_port
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W        = IODEC_ADDR_W,
   parameter int unsigned OFS_W         = IODEC_OFS_W,
   parameter int unsigned SW_W          = IODEC_SW_W,
   parameter bit          CLOSED_IS_ONE = 1'b1
) (
   input  logic [ADDR_W-1:0] io_addr_i,
   input  logic              dma_aen_i,
   input  logic              ior_n_i,
   input  logic              iow_n_i,
   input  logic              port_en_i,
   input  logic [SW_W-1:0]   sw_closed_i,
   output logic              sel_o,
   output logic [OFS_W-1:0]  reg_idx_o,
   output logic              rd_o,
   output logic              wr_o
);
   localparam int unsigned DEC_TOP = OFS_W + SW_W; // first ignored line

   initial begin
      if (ADDR_W < DEC_TOP) $error("iodec_port: ADDR_W below OFS_W+SW_W");
      if (OFS_W < 1)        $error("iodec_port: OFS_W must be at least 1");
   end

   logic [SW_W-1:0]  field;
   logic [OFS_W-1:0] ofs_raw;
   logic             line_hit;
   logic             sel;

   assign field   = io_addr_i[DEC_TOP-1:OFS_W];
   assign ofs_raw = io_addr_i[OFS_W-1:0];

   if (ADDR_W > DEC_TOP) begin : g_hi_lines
      logic unused_hi_lines;
      assign unused_hi_lines = ^io_addr_i[ADDR_W-1:DEC_TOP];
   end

   iodec_line_match #(
      .SW_W         (SW_W),
      .CLOSED_IS_ONE(CLOSED_IS_ONE)
   ) u_match (
      .addr_field_i(field),
      .sw_i        (sw_closed_i),
      .hit_o       (line_hit)
   );

   assign sel = line_hit & ~dma_aen_i & port_en_i;

   iodec_strobe_gate #(.OFS_W(OFS_W)) u_gate (
      .sel_i  (sel),
      .ofs_i  (ofs_raw),
      .ior_n_i(ior_n_i),
      .iow_n_i(iow_n_i),
      .ofs_o  (reg_idx_o),
      .rd_o   (rd_o),
      .wr_o   (wr_o)
   );

   assign sel_o = sel;

   always_comb begin
      a_r3_dma_never_selects:  assert (!(dma_aen_i && (sel_o || rd_o || wr_o)));
      a_r4_disabled_is_quiet:  assert (port_en_i || !(sel_o || rd_o || wr_o));
      a_r5_idx_zero_when_idle: assert (sel_o || reg_idx_o == '0);
      a_r1_sel_needs_hit:      assert (!sel_o || line_hit);
   end
endmodule

// File: tb/tb_iodec_port.sv
module tb_iodec_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr;
   logic        aen, ior_n, iow_n, pen;
   logic [7:0]  sw;
   logic        sel, rd, wr;
   logic [2:0]  idx;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done  = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   iodec_port dut (
      .io_addr_i(addr), .dma_aen_i(aen), .ior_n_i(ior_n), .iow_n_i(iow_n),
      .port_en_i(pen), .sw_closed_i(sw),
      .sel_o(sel), .reg_idx_o(idx), .rd_o(rd), .wr_o(wr)
   );

   // Expected select from the requirement wording (R1).
   function automatic bit exp_sel(input logic [15:0] a, input logic [7:0] s,
                                  input logic e, input logic p);
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++)
         if (s[i] ? (a[i+3] != 1'b0) : (a[i+3] != 1'b1)) ok = 1'b0;
      return ok && !e && p;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: addr=%h sw=%h actual=%h expected=%h", req, addr, sw, act, expv);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [7:0] s, input logic e,
                        input logic p, input logic rn, input logic wn, input string req);
      bit es;
      @(posedge clk);
      addr = a; sw = s; aen = e; pen = p; ior_n = rn; iow_n = wn;
      @(negedge clk);
      es = exp_sel(a, s, e, p);
      chk({req, " sel"}, {31'd0, sel}, {31'd0, es});
      chk({req, " R5 idx"}, {29'd0, idx}, es ? {29'd0, a[2:0]} : 32'd0);
      chk({req, " R6 rd"}, {31'd0, rd}, {31'd0, es & ~rn});
      chk({req, " R6 wr"}, {31'd0, wr}, {31'd0, es & ~wn});
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] bases [4] = '{16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8};
      logic [7:0]  sws   [4] = '{8'h80, 8'hA0, 8'h82, 8'hA2};
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      addr = 16'h03F8; sw = 8'h80; aen = 1'b0; pen = 1'b0; ior_n = 1'b1; iow_n = 1'b1;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: disabled port is quiet (R4)
      @(negedge clk);
      chk("R4 reset sel", {31'd0, sel}, 32'd0);
      chk("R4 reset rd/wr", {30'd0, rd, wr}, 32'd0);

      // R8: four customary bases, every offset, and the two neighbours
      for (int b = 0; b < 4; b++) begin
         for (int o = 0; o < 8; o++)
            apply(bases[b] + 16'(o), sws[b], 1'b0, 1'b1, o[0], ~o[0], "R8 R1 in-window");
         apply(bases[b] - 16'd1, sws[b], 1'b0, 1'b1, 1'b0, 1'b1, "R8 R7 base-1");
         apply(bases[b] + 16'd8, sws[b], 1'b0, 1'b1, 1'b1, 1'b0, "R8 R7 base+8");
         chk("R8 window edge", {31'd0, sel}, 32'd0);
      end
      // R2: high lines set
      apply(16'hF3FA, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1, "R2 high lines");
      chk("R2 hit despite high lines", {31'd0, sel}, 32'd1);
      // R3: DMA cycle at a matching address
      apply(16'h03F9, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, "R3 dma");
      chk("R3 no strobes in dma", {30'd0, rd, wr}, 32'd0);
      // R4: disabled port at a matching address
      apply(16'h02FC, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 disabled");
      chk("R4 no sel when disabled", {31'd0, sel}, 32'd0);
      // R7: strobes outside the window
      apply(16'h0100, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, "R7 outside");
      chk("R7 no strobe outside", {30'd0, rd, wr}, 32'd0);

      // seeded random cycles; half aimed at the window
      for (int k = 0; k < 600; k++) begin
         logic [15:0] a = 16'($urandom);
         logic [7:0]  s = 8'($urandom);
         if (k % 2 == 0) a[10:3] = ~s;
         apply(a, s, ($urandom % 5) == 0, ($urandom % 6) != 0,
               1'($urandom), 1'($urandom), "R1 R2 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule